// File: doc/BRIEF.md
# Instruction Fetch and RAM Bounds Monitor

This block sits beside a small CPU's memory bus and watches each bus cycle. It flags a violation in three cases. The first is an instruction fetch that lands inside a window set by software, once that window is armed. The second is an instruction fetch from the firmware RAM range, which is never executable. The third is any access, of any type, that falls inside the RAM address region but above the RAM that is physically fitted. A violation sets a sticky trap flag. From the next cycle on, the block replaces the read data going back to the CPU with an all-zero word. That word is an illegal instruction, so the CPU traps. Only a reset clears the flag.

Firmware sets up the monitor through a small register port: an enable register, a window start register and a window end register. Enabling is one-way. Once the monitor is armed, both window bounds are frozen until the next reset. A registered trap-detected output lets other logic react to the trap.

Top module: `fetch_monitor`

## Requirements
- R1: After a synchronous reset, the enable bit reads 0, both window bounds read 0, trap_detected is 0, and cpu_rdata equals mem_rdata.
- R2: Register word addresses are 0x00 for control (enable in bit 0), 0x01 for window start and 0x02 for window end. A read (cfg_cs=1, cfg_we=0) returns the word on cfg_rdata in the next cycle. Unmapped addresses read 0, and cfg_rdata is 0 in any cycle that follows no read.
- R3: Writing 1 to control bit 0 arms the monitor. Writing 0 has no effect, so the monitor stays armed until reset.
- R4: While the monitor is armed, writes to window start and window end are ignored.
- R5: With the monitor armed, a fetch (bus_valid=1, bus_instr=1) whose address is at or above the start and at or below the end is a violation. Data accesses to the window, and fetches just outside either bound, are not violations.
- R6: With the monitor disarmed, fetches inside the programmed window are not violations.
- R7: A fetch inside the firmware RAM range [FW_BASE, FW_BASE+FW_SIZE) is always a violation, armed or not. Data accesses there are not violations.
- R8: Any valid access, fetch or data, inside [RAM_BASE+RAM_PHYS, RAM_BASE+RAM_SPAN) is a violation. The last physical word and addresses past the region are not violations.
- R9: From the cycle after a violation until reset, cpu_rdata is the all-zero illegal instruction whatever mem_rdata holds.
- R10: trap_detected rises one cycle after the trap flag is set, which is two clock edges after the violating bus cycle, and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cs | input | 1 | Register port select |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 8 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, one cycle after the request |
| bus_valid | input | 1 | CPU bus cycle valid |
| bus_instr | input | 1 | Bus cycle is an instruction fetch |
| bus_addr | input | 32 | CPU bus address |
| mem_rdata | input | 32 | Read data from the memory system |
| cpu_rdata | output | 32 | Read data delivered to the CPU |
| trap_detected | output | 1 | Sticky trap indication |

## Verification
The bench keeps the default RAM region base and span and the default firmware RAM placement. It shrinks the physical RAM size to 0x1000 so that the boundary between fitted and missing RAM is easy to hit. With these values the bench can reach both sides of every bound in a few cycles: the last physical word, the first missing word, the address just past the RAM region, both ends of the firmware range, and both inclusive edges of the software window. A reset between scenarios clears the sticky trap so that each violation type is seen on its own.

// File: rtl/mon_pkg.sv
package mon_pkg;
  typedef enum logic [7:0] {
    SEL_CTRL = 8'h00,
    SEL_LO   = 8'h01,
    SEL_HI   = 8'h02
  } reg_sel_e;

  localparam int ARM_BIT = 0;
endpackage

// File: rtl/mon_cfg_regs.sv
module mon_cfg_regs #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SEL_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              we,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              armed,
  output logic [ADDR_W-1:0] lo,
  output logic [ADDR_W-1:0] hi
);
  import mon_pkg::*;

  logic wr_ctrl, wr_lo, wr_hi, rd;

  assign wr_ctrl = cs && we && (sel == SEL_W'(SEL_CTRL));
  assign wr_lo   = cs && we && (sel == SEL_W'(SEL_LO)) && !armed;
  assign wr_hi   = cs && we && (sel == SEL_W'(SEL_HI)) && !armed;
  assign rd      = cs && !we;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      lo    <= '0;
      hi    <= '0;
    end else begin
      if (wr_ctrl && wdata[ARM_BIT]) armed <= 1'b1;
      if (wr_lo) lo <= wdata[ADDR_W-1:0];
      if (wr_hi) hi <= wdata[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !rd) begin
      rdata <= '0;
    end else begin
      case (sel)
        SEL_W'(SEL_CTRL): rdata <= DATA_W'(armed);
        SEL_W'(SEL_LO):   rdata <= DATA_W'(lo);
        SEL_W'(SEL_HI):   rdata <= DATA_W'(hi);
        default:          rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/mon_detect.sv
module mon_detect #(
  parameter int              ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] RAM_BASE = 32'h4000_0000,
  parameter logic [ADDR_W-1:0] RAM_SPAN = 32'h4000_0000,
  parameter logic [ADDR_W-1:0] RAM_PHYS = 32'h0002_0000,
  parameter logic [ADDR_W-1:0] FW_BASE  = 32'hD000_0000,
  parameter logic [ADDR_W-1:0] FW_SIZE  = 32'h0000_0800
) (
  input  logic              valid,
  input  logic              instr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              armed,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  output logic              viol
);
  localparam int NRULE = 3;
  localparam logic [ADDR_W:0] PHYS_END = {1'b0, RAM_BASE} + {1'b0, RAM_PHYS};
  localparam logic [ADDR_W:0] REG_END  = {1'b0, RAM_BASE} + {1'b0, RAM_SPAN};
  localparam logic [ADDR_W:0] FW_LO    = {1'b0, FW_BASE};
  localparam logic [ADDR_W:0] FW_END   = {1'b0, FW_BASE} + {1'b0, FW_SIZE};

  logic [ADDR_W:0]  ax;
  logic [NRULE-1:0] hit;

  assign ax = {1'b0, addr};

  for (genvar g = 0; g < NRULE; g++) begin : g_rule
    if (g == 0) begin : g_win
      assign hit[g] = armed && valid && instr && (addr >= lo) && (addr <= hi);
    end else if (g == 1) begin : g_fw
      assign hit[g] = valid && instr && (ax >= FW_LO) && (ax < FW_END);
    end else begin : g_ovf
      assign hit[g] = valid && (ax >= PHYS_END) && (ax < REG_END);
    end
  end

  assign viol = |hit;
endmodule

// File: rtl/mon_trap_latch.sv
module mon_trap_latch (
  input  logic clk,
  input  logic rst,
  input  logic set,
  output logic trap_q,
  output logic trap_seen
);
  always_ff @(posedge clk) begin
    if (rst) begin
      trap_q    <= 1'b0;
      trap_seen <= 1'b0;
    end else begin
      if (set) trap_q <= 1'b1;
      trap_seen <= trap_q;
    end
  end
endmodule

// File: rtl/fetch_monitor.sv
module fetch_monitor #(
  parameter int              ADDR_W   = 32,
  parameter int              DATA_W   = 32,
  parameter int              SEL_W    = 8,
  parameter logic [ADDR_W-1:0] RAM_BASE = 32'h4000_0000,
  parameter logic [ADDR_W-1:0] RAM_SPAN = 32'h4000_0000,
  parameter logic [ADDR_W-1:0] RAM_PHYS = 32'h0002_0000,
  parameter logic [ADDR_W-1:0] FW_BASE  = 32'hD000_0000,
  parameter logic [ADDR_W-1:0] FW_SIZE  = 32'h0000_0800
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_cs,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              bus_valid,
  input  logic              bus_instr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              trap_detected
);
  localparam logic [DATA_W-1:0] BAD_WORD = '0;

  logic              mon_en;
  logic [ADDR_W-1:0] win_lo, win_hi;
  logic              viol;
  logic              trap_q;

  mon_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst(rst), .cs(cfg_cs), .we(cfg_we), .sel(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .armed(mon_en), .lo(win_lo), .hi(win_hi)
  );

  mon_detect #(
    .ADDR_W(ADDR_W), .RAM_BASE(RAM_BASE), .RAM_SPAN(RAM_SPAN), .RAM_PHYS(RAM_PHYS),
    .FW_BASE(FW_BASE), .FW_SIZE(FW_SIZE)
  ) u_det (
    .valid(bus_valid), .instr(bus_instr), .addr(bus_addr), .armed(mon_en),
    .lo(win_lo), .hi(win_hi), .viol(viol)
  );

  mon_trap_latch u_trap (
    .clk(clk), .rst(rst), .set(viol), .trap_q(trap_q), .trap_seen(trap_detected)
  );

  assign cpu_rdata = trap_q ? BAD_WORD : mem_rdata;
endmodule

// File: rtl/mon_checker.sv
module mon_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              mon_en,
  input logic [ADDR_W-1:0] win_lo,
  input logic [ADDR_W-1:0] win_hi,
  input logic              bus_valid,
  input logic              bus_instr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              trap_q,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              trap_detected
);
  // R3
  arm_sticky_chk: assert property (@(posedge clk) disable iff (rst) mon_en |=> mon_en);
  // R4
  lo_frozen_chk: assert property (@(posedge clk) disable iff (rst) mon_en |=> $stable(win_lo));
  // R4
  hi_frozen_chk: assert property (@(posedge clk) disable iff (rst) mon_en |=> $stable(win_hi));
  // R5
  win_fetch_trap_chk: assert property (@(posedge clk) disable iff (rst)
    (mon_en && bus_valid && bus_instr && bus_addr >= win_lo && bus_addr <= win_hi) |=> trap_q);
  // R9
  bad_word_chk: assert property (@(posedge clk) disable iff (rst) trap_q |-> (cpu_rdata == '0));
  // R10
  seen_follows_chk: assert property (@(posedge clk) disable iff (rst) trap_q |=> trap_detected);
  // R10
  seen_sticky_chk: assert property (@(posedge clk) disable iff (rst) trap_detected |=> trap_detected);
endmodule

bind fetch_monitor mon_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .mon_en(mon_en), .win_lo(win_lo), .win_hi(win_hi),
  .bus_valid(bus_valid), .bus_instr(bus_instr), .bus_addr(bus_addr),
  .trap_q(trap_q), .cpu_rdata(cpu_rdata), .trap_detected(trap_detected)
);

// File: tb/fetch_monitor_bench.sv
module fetch_monitor_bench;
  localparam logic [31:0] RB  = 32'h4000_0000;
  localparam logic [31:0] RS  = 32'h4000_0000;
  localparam logic [31:0] RP  = 32'h0000_1000;
  localparam logic [31:0] FB  = 32'hD000_0000;
  localparam logic [31:0] FS  = 32'h0000_0800;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_cs = 0, cfg_we = 0, bus_valid = 0, bus_instr = 0;
  logic [7:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, bus_addr = '0, mem_rdata = 32'h1234_5678;
  logic [31:0] cfg_rdata, cpu_rdata;
  logic trap_detected;

  int checks = 0, fails = 0, cyc = 0;
  string cur_req = "R1";

  // reference model state
  bit m_en = 0, m_trap = 0, m_seen = 0;
  logic [31:0] m_lo = '0, m_hi = '0, m_rd = '0;

  always #2.5 clk = ~clk;

  fetch_monitor #(.RAM_BASE(RB), .RAM_SPAN(RS), .RAM_PHYS(RP), .FW_BASE(FB), .FW_SIZE(FS))
  u_fetch_monitor (
    .clk(clk), .rst(rst), .cfg_cs(cfg_cs), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_valid(bus_valid),
    .bus_instr(bus_instr), .bus_addr(bus_addr), .mem_rdata(mem_rdata),
    .cpu_rdata(cpu_rdata), .trap_detected(trap_detected)
  );

  always @(posedge clk) begin
    longint a;
    bit v;
    cyc++;
    if (rst) begin
      m_en = 0; m_lo = '0; m_hi = '0; m_trap = 0; m_seen = 0; m_rd = '0;
    end else begin
      a = longint'(bus_addr);
      v = 0;
      if (m_en && bus_valid && bus_instr && bus_addr >= m_lo && bus_addr <= m_hi) v = 1;
      if (bus_valid && bus_instr && a >= longint'(FB) && a < longint'(FB) + longint'(FS)) v = 1;
      if (bus_valid && a >= longint'(RB) + longint'(RP) && a < longint'(RB) + longint'(RS)) v = 1;
      m_seen = m_trap;
      m_trap = m_trap | v;
      if (cfg_cs && !cfg_we)
        m_rd = (cfg_addr == 0) ? {31'b0, m_en} : (cfg_addr == 1) ? m_lo :
               (cfg_addr == 2) ? m_hi : 32'h0;
      else m_rd = '0;
      if (cfg_cs && cfg_we) begin
        if (cfg_addr == 1 && !m_en) m_lo = cfg_wdata;
        if (cfg_addr == 2 && !m_en) m_hi = cfg_wdata;
        if (cfg_addr == 0 && cfg_wdata[0]) m_en = 1;
      end
    end
  end

  always @(negedge clk) begin
    logic [31:0] exp_cpu;
    exp_cpu = m_trap ? 32'h0 : mem_rdata;
    checks += 3;
    if (cfg_rdata !== m_rd) begin
      fails++; $display("FAIL %s cfg_rdata actual %h expected %h", cur_req, cfg_rdata, m_rd);
    end
    if (cpu_rdata !== exp_cpu) begin
      fails++; $display("FAIL %s cpu_rdata actual %h expected %h", cur_req, cpu_rdata, exp_cpu);
    end
    if (trap_detected !== m_seen) begin
      fails++; $display("FAIL %s trap_detected actual %b expected %b", cur_req, trap_detected, m_seen);
    end
  end

  task automatic step(input logic cs, input logic we, input logic [7:0] ra, input logic [31:0] wd,
                      input logic v, input logic ins, input logic [31:0] ba);
    @(posedge clk); #1;
    cfg_cs = cs; cfg_we = we; cfg_addr = ra; cfg_wdata = wd;
    bus_valid = v; bus_instr = ins; bus_addr = ba;
    mem_rdata = 32'hC0DE_0000 ^ 32'(cyc * 7 + 1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 8'h0, 32'h0, 0, 0, 32'h0);
  endtask

  task automatic wr(input logic [7:0] ra, input logic [31:0] wd);
    step(1, 1, ra, wd, 0, 0, 32'h0);
  endtask

  task automatic rd(input logic [7:0] ra);
    step(1, 0, ra, 32'h0, 0, 0, 32'h0);
  endtask

  task automatic do_reset();
    @(posedge clk); #1 rst = 1;
    idle(2);
    @(posedge clk); #1 rst = 0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog expired in phase %s", cur_req);
    finish_run();
  end

  initial begin
    cur_req = "R1";
    do_reset();
    rd(0); rd(1); rd(2); idle(1);
    cur_req = "R2";
    wr(1, 32'h0000_0100); wr(2, 32'h0000_01FF);
    rd(1); rd(2); rd(8'h05); rd(8'hFF); idle(1);
    cur_req = "R6";
    step(0, 0, 0, 0, 1, 1, 32'h0000_0150); step(0, 0, 0, 0, 1, 1, 32'h0000_0100);
    idle(2);
    cur_req = "R3";
    wr(0, 32'h0); rd(0); wr(0, 32'h1); rd(0); wr(0, 32'h0); rd(0); idle(1);
    cur_req = "R4";
    wr(1, 32'h0000_0000); wr(2, 32'hFFFF_FFFF); rd(1); rd(2); idle(1);
    cur_req = "R5";
    step(0, 0, 0, 0, 1, 0, 32'h0000_0150);
    step(0, 0, 0, 0, 1, 1, 32'h0000_00FF);
    step(0, 0, 0, 0, 1, 1, 32'h0000_0200);
    idle(2);
    step(0, 0, 0, 0, 1, 1, 32'h0000_01FF);
    cur_req = "R9";
    idle(1);
    cur_req = "R10";
    idle(5); rd(0); idle(1);

    cur_req = "R1";
    do_reset(); rd(0); rd(1); idle(1);
    cur_req = "R5";
    wr(1, 32'h0000_0100); wr(2, 32'h0000_0100); wr(0, 32'h1); idle(1);
    step(0, 0, 0, 0, 1, 1, 32'h0000_0100);
    cur_req = "R10";
    idle(4);

    cur_req = "R7";
    do_reset();
    step(0, 0, 0, 0, 1, 0, FB); step(0, 0, 0, 0, 1, 0, FB + 32'h10);
    step(0, 0, 0, 0, 1, 1, FB + FS); step(0, 0, 0, 0, 1, 1, FB - 32'h4);
    idle(2);
    step(0, 0, 0, 0, 1, 1, FB + FS - 32'h4);
    cur_req = "R9";
    idle(4);

    cur_req = "R7";
    do_reset();
    step(0, 0, 0, 0, 1, 1, FB);
    idle(4);

    cur_req = "R8";
    do_reset();
    step(0, 0, 0, 0, 1, 0, RB + RP - 32'h4);
    step(0, 0, 0, 0, 1, 1, RB);
    step(0, 0, 0, 0, 1, 0, RB + RS);
    step(0, 0, 0, 0, 0, 0, RB + RP);
    idle(2);
    step(0, 0, 0, 0, 1, 0, RB + RP);
    idle(4);
    do_reset();
    step(0, 0, 0, 0, 1, 1, RB + RS - 32'h4);
    idle(4);

    finish_run();
  end
endmodule